// File: doc/BRIEF.md
# Energy-to-Pulse Rate Converter

This block turns a stream of signed active-power words into metering pulses. Each positive power sample is added to two energy accumulators. When the counter accumulator reaches its threshold, the threshold is subtracted and one counter pulse is requested. The requests are steered in turn to two active-low outputs that can drive a stepper-motor register or an electromechanical counter. A second accumulator runs against a finer threshold and drives an active-high calibration pulse stream. That stream runs at a fixed multiple of the combined counter rate.

A three-bit rate select sets both thresholds. The low two bits pick the counter threshold in steps of two. The full select value picks the calibration-to-counter ratio. Counter pulses have a fixed width followed by an equal minimum idle time. Requests that arrive while a pulse is running are queued rather than dropped. The calibration pulse uses a nominal width, narrows to half of its period when pulses come closely spaced, and has a fixed narrow width in the fastest calibration mode. All times are counted in clock cycles and set by parameters, so a test build can use short pulses in place of the real-time values.

Top module: `energy_pulse_gen`

## Requirements
- R1: The counter threshold is T = 2^THR_LOG2 << (3 - freq_sel[1:0]). Each time the counter accumulator reaches T, one counter pulse is issued and T is subtracted, so any excess carries into the next pulse.
- R2: A sample whose power word is negative or zero (two's complement, bit PWR_W-1 is the sign) leaves both accumulators unchanged.
- R3: Counter pulses alternate between the two outputs, starting with e1_n after reset. The two outputs are never low at the same time.
- R4: Each counter pulse holds its output low for exactly CNT_WIDTH cycles. Both outputs then stay high for at least CNT_WIDTH cycles before the next counter pulse.
- R5: Counter requests that arrive while a pulse or its idle time is running are queued, up to 2^PEND_W-1 of them, and each is issued later as its own pulse.
- R6: The calibration threshold is T >> k. For freq_sel 0 through 7, k is 6, 5, 4, 11, 7, 6, 5 and 4. Each time the threshold is reached, one calibration pulse is issued.
- R7: Outside select 3, a calibration pulse is high for CAL_WIDTH cycles when the interval since the previous calibration request is at least 2*CAL_WIDTH cycles. Otherwise it is high for floor(interval/2) cycles, and never less than one cycle.
- R8: With freq_sel equal to 3, every calibration pulse is high for exactly CAL_NARROW cycles.
- R9: In reset and on the first cycle after it, e1_n and e2_n are high, cal_pulse is low, and both accumulators are empty.
- R10: Two select values that differ only in bit 2 use the same counter threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_valid | input | 1 | High for one cycle with each power sample |
| pwr_word | input | PWR_W | Signed active-power sample |
| freq_sel | input | 3 | Rate select for counter threshold and calibration ratio |
| e1_n | output | 1 | First counter output, active low |
| e2_n | output | 1 | Second counter output, active low |
| cal_pulse | output | 1 | Calibration pulse output, active high |

## Verification
The bench builds the block with THR_LOG2 = 12, CNT_WIDTH = 40, CAL_WIDTH = 10, CAL_NARROW = 2 and PWR_W = 16. This gives a counter threshold of 4096 to 32768, which a handful of samples can cross, and a calibration threshold as small as 2. With these values the full 2048:1 ratio of select 3 can be counted pulse by pulse. The short widths make it practical to drive calibration request intervals on both sides of 2*CAL_WIDTH, and to stack several counter requests inside one 81-cycle pulse-and-idle window so the queue and the alternation can be seen.

// File: rtl/epg_pkg.sv
package epg_pkg;

    typedef enum logic [1:0] {
        SH_IDLE   = 2'd0,
        SH_ACTIVE = 2'd1,
        SH_GAP    = 2'd2
    } shape_state_e;

    // Decoded rate select: shift amounts for both thresholds.
    typedef struct packed {
        logic [1:0] cnt_sh;   // counter threshold = base << cnt_sh
        logic [3:0] cal_sh;   // calibration threshold = counter >> cal_sh
        logic       narrow;   // fixed narrow calibration width
    } sel_cfg_t;

    function automatic sel_cfg_t decode_sel(input logic [2:0] s);
        sel_cfg_t c;
        c.cnt_sh = 2'd3 - s[1:0];
        case (s)
            3'd0:    c.cal_sh = 4'd6;
            3'd1:    c.cal_sh = 4'd5;
            3'd2:    c.cal_sh = 4'd4;
            3'd3:    c.cal_sh = 4'd11;
            3'd4:    c.cal_sh = 4'd7;
            3'd5:    c.cal_sh = 4'd6;
            3'd6:    c.cal_sh = 4'd5;
            default: c.cal_sh = 4'd4;
        endcase
        c.narrow = (s == 3'd3);
        return c;
    endfunction

endpackage

// File: rtl/epg_thresh.sv
module epg_thresh
    import epg_pkg::*;
#(
    parameter int THR_LOG2 = 20,
    parameter int ACC_W    = 25
) (
    input  sel_cfg_t           cfg,
    output logic [ACC_W-1:0]   cnt_thr,
    output logic [ACC_W-1:0]   cal_thr
);
    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    int cnt_pos;
    int cal_pos;

    always_comb begin
        cnt_pos = THR_LOG2 + int'(cfg.cnt_sh);
        cal_pos = cnt_pos - int'(cfg.cal_sh);
        cnt_thr = ONE << cnt_pos;
        cal_thr = ONE << cal_pos;
    end
endmodule

// File: rtl/epg_accum.sv
module epg_accum #(
    parameter int PWR_W = 16,
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [PWR_W-1:0] pwr,
    input  logic [ACC_W-1:0] thr,
    output logic             req
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] add;
    logic [ACC_W-1:0] sum;
    logic             positive;

    always_comb begin
        positive = valid && !pwr[PWR_W-1] && (|pwr);
        add      = positive ? {{(ACC_W-PWR_W){1'b0}}, pwr} : '0;
        sum      = acc_q + add;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            req   <= 1'b0;
        end else if (sum >= thr) begin
            acc_q <= sum - thr;
            req   <= 1'b1;
        end else begin
            acc_q <= sum;
            req   <= 1'b0;
        end
    end
endmodule

// File: rtl/epg_shaper.sv
module epg_shaper
    import epg_pkg::*;
#(
    parameter int CW     = 20,
    parameter int PEND_W = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] gap,
    output logic          active,
    output logic          last
);
    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

    shape_state_e      state_q;
    logic [CW-1:0]     cnt_q;
    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] pend_n;
    logic              start;

    always_comb begin
        start  = (state_q == SH_IDLE) && (req || (pend_q != '0));
        pend_n = pend_q;
        case ({req, start})
            2'b10:   pend_n = (pend_q == PMAX) ? pend_q : pend_q + 1'b1;
            2'b01:   pend_n = pend_q - 1'b1;
            default: pend_n = pend_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            pend_q  <= '0;
        end else begin
            pend_q <= pend_n;
            case (state_q)
                SH_IDLE: begin
                    if (start) begin
                        state_q <= SH_ACTIVE;
                        cnt_q   <= width - 1'b1;
                    end
                end
                SH_ACTIVE: begin
                    if (cnt_q == '0) begin
                        state_q <= SH_GAP;
                        cnt_q   <= gap - 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == '0) state_q <= SH_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign active = (state_q == SH_ACTIVE);
    assign last   = (state_q == SH_ACTIVE) && (cnt_q == '0);
endmodule

// File: rtl/epg_cal_width.sv
module epg_cal_width #(
    parameter int CW         = 20,
    parameter int CAL_WIDTH  = 368640,
    parameter int CAL_NARROW = 82
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          narrow,
    output logic [CW-1:0] width
);
    localparam int SAT = 2 * CAL_WIDTH;
    localparam int IW  = $clog2(SAT + 2);
    localparam logic [IW-1:0] SAT_V = IW'(SAT);

    logic [IW-1:0] per_q;
    logic [IW-1:0] interval;
    logic [IW-1:0] half;
    logic [CW-1:0] wnext;
    logic [CW-1:0] width_q;

    always_comb begin
        interval = per_q + 1'b1;
        half     = interval >> 1;
        if (narrow)                wnext = CW'(CAL_NARROW);
        else if (interval >= SAT_V) wnext = CW'(CAL_WIDTH);
        else if (half == '0)       wnext = CW'(1);
        else                       wnext = CW'(half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q   <= SAT_V;
            width_q <= CW'(CAL_WIDTH);
        end else if (req) begin
            per_q   <= '0;
            width_q <= wnext;
        end else if (per_q < SAT_V) begin
            per_q <= per_q + 1'b1;
        end
    end

    assign width = req ? wnext : width_q;
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
    import epg_pkg::*;
#(
    parameter int PWR_W      = 16,
    parameter int THR_LOG2   = 20,
    parameter int CNT_WIDTH  = 1024000,
    parameter int CAL_WIDTH  = 368640,
    parameter int CAL_NARROW = 82,
    parameter int PEND_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_valid,
    input  logic [PWR_W-1:0] pwr_word,
    input  logic [2:0]       freq_sel,
    output logic             e1_n,
    output logic             e2_n,
    output logic             cal_pulse
);
    localparam int TOPBIT = (THR_LOG2 + 3 > PWR_W - 1) ? THR_LOG2 + 3 : PWR_W - 1;
    localparam int ACC_W  = TOPBIT + 2;
    localparam int WMAX0  = (CNT_WIDTH > CAL_WIDTH) ? CNT_WIDTH : CAL_WIDTH;
    localparam int WMAX   = (WMAX0 > CAL_NARROW) ? WMAX0 : CAL_NARROW;
    localparam int CW     = $clog2(WMAX + 1);
    localparam int NACC   = 2;   // 0: counter path, 1: calibration path

    sel_cfg_t         cfg;
    logic [ACC_W-1:0] thr_v [NACC];
    logic             req_v [NACC];

    logic [CW-1:0] cal_w;
    logic          cnt_act, cnt_last, cal_act, cal_last;
    logic          side_q;

    assign cfg = decode_sel(freq_sel);

    epg_thresh #(.THR_LOG2(THR_LOG2), .ACC_W(ACC_W)) u_thr (
        .cfg     (cfg),
        .cnt_thr (thr_v[0]),
        .cal_thr (thr_v[1])
    );

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        epg_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .valid (pwr_valid),
            .pwr   (pwr_word),
            .thr   (thr_v[g]),
            .req   (req_v[g])
        );
    end

    epg_shaper #(.CW(CW), .PEND_W(PEND_W)) u_cnt_sh (
        .clk    (clk),
        .rst    (rst),
        .req    (req_v[0]),
        .width  (CW'(CNT_WIDTH)),
        .gap    (CW'(CNT_WIDTH)),
        .active (cnt_act),
        .last   (cnt_last)
    );

    epg_cal_width #(.CW(CW), .CAL_WIDTH(CAL_WIDTH), .CAL_NARROW(CAL_NARROW)) u_calw (
        .clk    (clk),
        .rst    (rst),
        .req    (req_v[1]),
        .narrow (cfg.narrow),
        .width  (cal_w)
    );

    epg_shaper #(.CW(CW), .PEND_W(PEND_W)) u_cal_sh (
        .clk    (clk),
        .rst    (rst),
        .req    (req_v[1]),
        .width  (cal_w),
        .gap    (CW'(1)),
        .active (cal_act),
        .last   (cal_last)
    );

    // Steering toggles at the end of each counter pulse.
    always_ff @(posedge clk) begin
        if (rst)           side_q <= 1'b0;
        else if (cnt_last) side_q <= ~side_q;
    end

    assign e1_n      = ~(cnt_act & ~side_q);
    assign e2_n      = ~(cnt_act &  side_q);
    assign cal_pulse = cal_act;

    logic unused_ok;
    assign unused_ok = cal_last;
endmodule

// File: rtl/epg_checker.sv
module epg_checker #(
    parameter int CNT_WIDTH = 1024000,
    parameter int CAL_WIDTH = 368640
) (
    input logic clk,
    input logic rst,
    input logic e1_n,
    input logic e2_n,
    input logic cal_pulse
);
    logic       lo;
    int         lo_run;
    int         hi_run;
    int         cal_run;
    logic [1:0] last_side;

    assign lo = !e1_n || !e2_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run    <= 0;
            hi_run    <= CNT_WIDTH;
            cal_run   <= 0;
            last_side <= 2'd0;
        end else begin
            lo_run  <= lo ? lo_run + 1 : 0;
            cal_run <= cal_pulse ? cal_run + 1 : 0;
            if (lo)                     hi_run <= 0;
            else if (hi_run < CNT_WIDTH) hi_run <= hi_run + 1;
            if (!e1_n)      last_side <= 2'd1;
            else if (!e2_n) last_side <= 2'd2;
        end
    end

    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!e1_n && !e2_n));

    p_alt_e1_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(e1_n) |-> last_side != 2'd1);

    p_alt_e2_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(e2_n) |-> last_side == 2'd1);

    p_cnt_width_r4: assert property (@(posedge clk) disable iff (rst)
        (!lo && lo_run != 0) |-> lo_run == CNT_WIDTH);

    p_cnt_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (lo && lo_run == 0) |-> hi_run >= CNT_WIDTH);

    p_cal_max_r7: assert property (@(posedge clk) disable iff (rst)
        cal_pulse |-> cal_run < CAL_WIDTH);

    p_reset_idle_r9: assert property (@(posedge clk)
        $fell(rst) |-> (e1_n && e2_n && !cal_pulse));
endmodule

bind energy_pulse_gen epg_checker #(
    .CNT_WIDTH (CNT_WIDTH),
    .CAL_WIDTH (CAL_WIDTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .e1_n      (e1_n),
    .e2_n      (e2_n),
    .cal_pulse (cal_pulse)
);

// File: tb/energy_pulse_gen_tb.sv
module energy_pulse_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PWR_W      = 16;
    localparam int THR_LOG2   = 12;
    localparam int CNT_W      = 40;
    localparam int CAL_W      = 10;
    localparam int CAL_N      = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_valid = 1'b0;
    logic [PWR_W-1:0] pwr_word = '0;
    logic [2:0]       freq_sel = 3'd0;
    logic             e1_n, e2_n, cal_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    energy_pulse_gen #(
        .PWR_W(PWR_W), .THR_LOG2(THR_LOG2), .CNT_WIDTH(CNT_W),
        .CAL_WIDTH(CAL_W), .CAL_NARROW(CAL_N), .PEND_W(4)
    ) u_dut (
        .clk(clk), .rst(rst), .pwr_valid(pwr_valid), .pwr_word(pwr_word),
        .freq_sel(freq_sel), .e1_n(e1_n), .e2_n(e2_n), .cal_pulse(cal_pulse)
    );

    // Monitor, sampled on the falling edge
    int e1_cnt, e2_cnt, cal_cnt, alt_err, first_side, last_side;
    int lo_len, hi_len, w_min, w_max, gap_min, ended;
    int cal_len, cw_min, cw_max, cw_last;
    logic p_e1 = 1'b1, p_e2 = 1'b1, p_lo = 1'b0, p_cal = 1'b0;

    task automatic clear_mon();
        e1_cnt = 0; e2_cnt = 0; cal_cnt = 0; alt_err = 0;
        first_side = 0; last_side = 0; lo_len = 0; hi_len = 0;
        w_min = 1 << 30; w_max = 0; gap_min = 1 << 30; ended = 0;
        cal_len = 0; cw_min = 1 << 30; cw_max = 0; cw_last = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!e1_n && p_e1) begin
                e1_cnt++; if (last_side == 1) alt_err++;
                if (first_side == 0) first_side = 1;
                last_side = 1;
            end
            if (!e2_n && p_e2) begin
                e2_cnt++; if (last_side != 1) alt_err++;
                if (first_side == 0) first_side = 2;
                last_side = 2;
            end
            if (!e1_n && !e2_n) alt_err++;
            if (!e1_n || !e2_n) begin
                if (!p_lo && ended != 0 && hi_len < gap_min) gap_min = hi_len;
                lo_len++;
            end else begin
                if (p_lo) begin
                    if (lo_len < w_min) w_min = lo_len;
                    if (lo_len > w_max) w_max = lo_len;
                    lo_len = 0; hi_len = 0; ended = 1;
                end
                hi_len++;
            end
            if (cal_pulse) begin
                if (!p_cal) cal_cnt++;
                cal_len++;
            end else if (p_cal) begin
                if (cal_len < cw_min) cw_min = cal_len;
                if (cal_len > cw_max) cw_max = cal_len;
                cw_last = cal_len; cal_len = 0;
            end
        end
        p_e1 = e1_n; p_e2 = e2_n; p_lo = !e1_n || !e2_n; p_cal = cal_pulse;
    end

    task automatic check_eq(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input string what, input longint act, input longint lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected >= %0d", tag, what, act, lim);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset(input logic [2:0] sel);
        @(posedge clk); #1;
        rst = 1'b1; pwr_valid = 1'b0; pwr_word = '0; freq_sel = sel;
        idle(3);
        rst = 1'b0;
        clear_mon();
    endtask

    // One sample, then idle so the next sample lands 'space' cycles later
    task automatic feed(input int v, input int space);
        pwr_valid = 1'b1; pwr_word = PWR_W'(v);
        @(posedge clk); #1;
        pwr_valid = 1'b0;
        repeat (space - 1) begin @(posedge clk); #1; end
    endtask

    task automatic t_reset();
        @(posedge clk); #1; rst = 1'b1; idle(2);
        #2;
        check_eq("R9", "e1_n in reset", e1_n, 1);
        check_eq("R9", "e2_n in reset", e2_n, 1);
        check_eq("R9", "cal_pulse in reset", cal_pulse, 0);
        do_reset(3'd3);
        idle(20);
        check_eq("R9", "no pulse after reset", e1_cnt + e2_cnt + cal_cnt, 0);
    endtask

    task automatic t_threshold();
        do_reset(3'd3);                  // T = 4096
        feed(4000, 2); feed(95, 2);
        idle(60);
        check_eq("R1", "below threshold count", e1_cnt + e2_cnt, 0);
        feed(1, 2); idle(100);
        check_eq("R1", "at threshold count", e1_cnt, 1);
        check_eq("R3", "first pulse on e1", first_side, 1);
        feed(5000, 2); idle(100);        // leaves 904
        check_eq("R1", "pulse on 5000", e1_cnt + e2_cnt, 2);
        check_eq("R3", "second pulse on e2", e2_cnt, 1);
        feed(3191, 2); idle(100);
        check_eq("R1", "excess carried, still short", e1_cnt + e2_cnt, 2);
        feed(1, 2); idle(100);
        check_eq("R1", "excess carried, reaches T", e1_cnt + e2_cnt, 3);
    endtask

    task automatic t_select_bit2();
        for (int s = 0; s < 2; s++) begin
            do_reset(s == 0 ? 3'd0 : 3'd4);   // T = 32768
            feed(32767, 2); idle(60);
            check_eq("R10", $sformatf("sel %0d short of T", s*4), e1_cnt + e2_cnt, 0);
            feed(1, 2); idle(100);
            check_eq("R10", $sformatf("sel %0d at T", s*4), e1_cnt + e2_cnt, 1);
        end
        do_reset(3'd7);                       // T = 4096, same as select 3
        feed(4096, 2); idle(100);
        check_eq("R10", "sel 7 at 4096", e1_cnt + e2_cnt, 1);
    endtask

    task automatic t_negative();
        do_reset(3'd3);
        feed(-5000, 2); feed(-32768, 2); feed(0, 2); feed(-1, 2); feed(4095, 2);
        idle(100);
        check_eq("R2", "negatives add nothing", e1_cnt + e2_cnt, 0);
        check_eq("R2", "no calibration pulse beyond 4095 share", cal_cnt >= 1, 1);
        feed(1, 2); idle(100);
        check_eq("R2", "accumulator intact", e1_cnt + e2_cnt, 1);
    endtask

    task automatic t_queue();
        do_reset(3'd7);                      // T = 4096
        feed(16384, 2);
        idle(450);
        check_eq("R5", "four queued pulses", e1_cnt + e2_cnt, 4);
        check_eq("R3", "e1 share", e1_cnt, 2);
        check_eq("R3", "e2 share", e2_cnt, 2);
        check_eq("R3", "alternation errors", alt_err, 0);
        check_eq("R4", "min counter width", w_min, CNT_W);
        check_eq("R4", "max counter width", w_max, CNT_W);
        check_ge("R4", "gap between counter pulses", gap_min, CNT_W);
    endtask

    task automatic t_ratio();
        int ratio [8] = '{64, 32, 16, 2048, 128, 64, 32, 16};
        for (int s = 0; s < 8; s++) begin
            int t_cnt, chunk, sp;
            t_cnt = 4096 << (3 - (s % 4));
            chunk = t_cnt / ratio[s];
            sp    = (s == 3) ? 6 : 30;
            do_reset(3'(s));
            for (int i = 0; i < ratio[s]; i++) feed(chunk, sp);
            idle(120);
            check_eq("R6", $sformatf("sel %0d calibration count", s), cal_cnt, ratio[s]);
            check_eq("R6", $sformatf("sel %0d counter count", s), e1_cnt + e2_cnt, 1);
            if (s == 3) begin
                check_eq("R8", "narrow min width", cw_min, CAL_N);
                check_eq("R8", "narrow max width", cw_max, CAL_N);
            end
        end
    endtask

    task automatic t_cal_width();
        int sp [3] = '{30, 8, 5};
        int ex [3] = '{CAL_W, 4, 2};
        for (int k = 0; k < 3; k++) begin
            do_reset(3'd0);                  // calibration threshold 512
            for (int i = 0; i < 12; i++) feed(512, sp[k]);
            idle(30);
            check_eq("R7", $sformatf("interval %0d width", sp[k]), cw_last, ex[k]);
            check_eq("R7", $sformatf("interval %0d count", sp[k]), cal_cnt, 12);
        end
    endtask

    initial begin
        clear_mon();
        t_reset();
        t_threshold();
        t_select_bit2();
        t_negative();
        t_queue();
        t_ratio();
        t_cal_width();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule